// File: doc/BRIEF.md
# Tagged-Status Integer Execution Unit

This block is a 64-bit integer execution unit in which every register value and every memory word carries a 7-bit status tag next to its data. Arithmetic never raises an exception on its own. Each result receives freshly computed carry, overflow, zero and negative flags. The accumulating bits (a poison bit for speculative faults and two user bits) are merged in from the source operands. Faults and flags therefore travel with the values through registers and memory. They take effect only when software issues an explicit masked test, which then produces a branch-taken pulse or a trap request.

The unit holds the tagged register file, the ALU, a word-aligned tagged memory and the test decision logic. Instructions arrive already decoded on the issue port. An instruction is accepted when `iss_valid` and `iss_ready` are both high. Every register write lands in a single write-back stage one cycle after issue. An instruction that reads or writes the register still waiting in that stage is held for one cycle. A registered observation port reads out any register with its tag.

Top module: `tagged_exec_unit`

## Requirements
- R1: Opcode 0 adds, opcode 1 subtracts (rs1 minus rs2), opcode 2 is bitwise AND and opcode 3 is bitwise OR, each writing rd. The carry tag (bit 1) is the unsigned carry-out for add, the borrow (rs1 < rs2 unsigned) for subtract, and 0 for logic operations. The overflow tag (bit 2) is signed overflow for add or subtract, and 0 for logic operations.
- R2: For every ALU and immediate-load result, the zero tag (bit 3) is set exactly when the 64-bit result is 0, and the negative tag (bit 4) equals result bit 63.
- R3: For opcodes 0 to 3, the poison tag (bit 0) and the user tags (bits 5 and 6) of the result are the OR of those bits in the two sources. Using a tagged operand never raises a trap.
- R4: Opcode 4 writes the 64-bit immediate to rd. Its poison and user tags are 0.
- R5: Opcode 6 stores rs2's data and tag to the word at rs1 + imm (byte address, word index = address bits [10:3]) and never traps. Opcode 5 loads a word into rd, restoring exactly the stored data and tag.
- R6: A load whose address has any of bits [2:0] set writes data 0 with only the poison tag set. A store to such an address changes no memory word.
- R7: Opcode 7 tests rs1's tag against the 7-bit mask. If any masked bit is set, the cycle after issue shows a one-cycle pulse on `br_taken` when the mode bit is 0, or on `trap_req` when the mode bit is 1. Otherwise neither output pulses. The two outputs are never high together.
- R8: Opcode 8 copies rs1 to rd. For each user tag bit (5 or 6) selected in the mask, it sets the bit when the mode bit is 1 and clears it when the mode bit is 0. Data and all other tag bits are unchanged.
- R9: While a register write is pending in write-back, an instruction that reads that register or writes it as rd sees `iss_ready` low for one cycle. It then executes with the updated value and never overtakes the pending write. Instructions that use other registers are not held.
- R10: After reset, `iss_ready` is 1 and `br_taken` and `trap_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction present on the issue port |
| iss_ready | output | 1 | Instruction accepted this cycle (low on a hazard) |
| iss_op | input | 4 | Operation code (0 to 8) |
| iss_rd | input | 4 | Destination register |
| iss_rs1 | input | 4 | First source, base address or tested register |
| iss_rs2 | input | 4 | Second source or store data register |
| iss_imm | input | 64 | Immediate value or byte offset |
| iss_mask | input | 7 | Tag mask for test and user-tag operations |
| iss_mode | input | 1 | Test: 1 = trap, 0 = branch. User-tag op: 1 = set, 0 = clear |
| br_taken | output | 1 | Registered branch decision from a test |
| trap_req | output | 1 | Registered trap request from a test |
| obs_addr | input | 4 | Register selected for observation |
| obs_data | output | 64 | Data of the observed register, one cycle later |
| obs_tag | output | 7 | Tag of the observed register, one cycle later |

## Verification
On every cycle, the assertions check the following. The two test outputs are never high together. A trap request only follows an accepted trap-mode test. A misaligned load always yields a poison-only result. Arithmetic results never lose a sticky bit that one of their sources carried. No write is accepted into the register held in write-back. The exact flag values, the tag round trip through memory, the ignored misaligned store, the set and clear of user bits and the length of each stall depend on chosen operand values and instruction orderings. The directed scenarios of the bench are what show these.

// File: rtl/tagexec_pkg.sv
package tagexec_pkg;
  localparam int TAG_W  = 7;
  localparam int T_PSN  = 0;
  localparam int T_CRY  = 1;
  localparam int T_OVF  = 2;
  localparam int T_ZRO  = 3;
  localparam int T_NEG  = 4;

  typedef logic [TAG_W-1:0] tag_t;

  localparam tag_t STICKY_BITS = 7'b110_0001;
  localparam tag_t USER_BITS   = 7'b110_0000;
  localparam tag_t POISON_ONLY = 7'b000_0001;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_LDI  = 4'd4,
    OP_LD   = 4'd5,
    OP_ST   = 4'd6,
    OP_TEST = 4'd7,
    OP_TAGU = 4'd8
  } op_e;
endpackage

// File: rtl/tag_regfile.sv
module tag_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [RW-1:0]                wa,
  input  logic [XLEN-1:0]              wd,
  input  tagexec_pkg::tag_t            wt,
  input  logic [RW-1:0]                ra1,
  input  logic [RW-1:0]                ra2,
  input  logic [RW-1:0]                ra3,
  output logic [XLEN-1:0]              rd1,
  output tagexec_pkg::tag_t            rt1,
  output logic [XLEN-1:0]              rd2,
  output tagexec_pkg::tag_t            rt2,
  output logic [XLEN-1:0]              rd3,
  output tagexec_pkg::tag_t            rt3
);
  import tagexec_pkg::*;
  localparam int EW = XLEN + TAG_W;

  logic [EW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[wa] <= {wt, wd};
  end

  assign {rt1, rd1} = regs[ra1];
  assign {rt2, rd2} = regs[ra2];
  assign {rt3, rd3} = regs[ra3];
endmodule

// File: rtl/tag_mem.sv
module tag_mem #(
  parameter int WIDTH = 71,
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end
endmodule

// File: rtl/tag_alu.sv
module tag_alu #(
  parameter int XLEN = 64
) (
  input  tagexec_pkg::op_e   op,
  input  logic [XLEN-1:0]    a,
  input  logic [XLEN-1:0]    b,
  input  tagexec_pkg::tag_t  ta,
  input  tagexec_pkg::tag_t  tb,
  input  logic [XLEN-1:0]    imm,
  input  tagexec_pkg::tag_t  umask,
  input  logic               uset,
  output logic [XLEN-1:0]    res,
  output tagexec_pkg::tag_t  rtag
);
  import tagexec_pkg::*;
  localparam int MSB = XLEN - 1;

  logic [XLEN:0] sum_w, dif_w;
  logic          cry, ovf;
  tag_t          carried, usel;

  assign sum_w = {1'b0, a} + {1'b0, b};
  assign dif_w = {1'b0, a} - {1'b0, b};
  assign usel  = umask & USER_BITS;

  always_comb begin
    res     = a;
    cry     = 1'b0;
    ovf     = 1'b0;
    carried = (ta | tb) & STICKY_BITS;
    case (op)
      OP_ADD: begin
        res = sum_w[MSB:0];
        cry = sum_w[XLEN];
        ovf = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res = dif_w[MSB:0];
        cry = dif_w[XLEN];
        ovf = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_LDI: begin
        res     = imm;
        carried = '0;
      end
      default: res = a;
    endcase

    if (op == OP_TAGU) begin
      rtag = uset ? (ta | usel) : (ta & ~usel);
    end else begin
      rtag        = carried;
      rtag[T_CRY] = cry;
      rtag[T_OVF] = ovf;
      rtag[T_ZRO] = (res == '0);
      rtag[T_NEG] = res[MSB];
    end
  end
endmodule

// File: rtl/tagged_exec_unit.sv
module tagged_exec_unit #(
  parameter int XLEN      = 64,
  parameter int NREG      = 16,
  parameter int MEM_WORDS = 256,
  localparam int RW       = $clog2(NREG),
  localparam int MAW      = $clog2(MEM_WORDS),
  localparam int TW       = tagexec_pkg::TAG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic [3:0]      iss_op,
  input  logic [RW-1:0]   iss_rd,
  input  logic [RW-1:0]   iss_rs1,
  input  logic [RW-1:0]   iss_rs2,
  input  logic [XLEN-1:0] iss_imm,
  input  logic [TW-1:0]   iss_mask,
  input  logic            iss_mode,
  output logic            br_taken,
  output logic            trap_req,
  input  logic [RW-1:0]   obs_addr,
  output logic [XLEN-1:0] obs_data,
  output logic [TW-1:0]   obs_tag
);
  import tagexec_pkg::*;
  localparam int OFFB = 3;
  localparam int EW   = XLEN + TAG_W;

  op_e op;
  assign op = op_e'(iss_op);

  // operand read
  logic [XLEN-1:0] s1_d, s2_d, ob_d;
  tag_t            s1_t, s2_t, ob_t;

  // write-back stage
  logic            wb_valid, wb_load, wb_misal;
  logic [RW-1:0]   wb_rd;
  logic [XLEN-1:0] wb_alu_d;
  tag_t            wb_alu_t;
  logic [XLEN-1:0] wr_d;
  tag_t            wr_t;

  // memory
  logic [EW-1:0]   mem_rd;
  logic [XLEN-1:0] addr;
  logic            misal, mem_we;

  // alu
  logic [XLEN-1:0] alu_d;
  tag_t            alu_t;

  logic uses_a, uses_b, writes, hazard, fire, is_arith;

  always_comb begin
    uses_a   = (op != OP_LDI);
    uses_b   = (op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_ST});
    writes   = (op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_LDI, OP_LD, OP_TAGU});
    is_arith = (op inside {OP_ADD, OP_SUB, OP_AND, OP_OR});
  end

  assign hazard    = wb_valid && ((uses_a && iss_rs1 == wb_rd) ||
                                  (uses_b && iss_rs2 == wb_rd) ||
                                  (writes && iss_rd  == wb_rd));
  assign iss_ready = !hazard;
  assign fire      = iss_valid && iss_ready;

  assign addr   = s1_d + iss_imm;
  assign misal  = |addr[OFFB-1:0];
  assign mem_we = fire && (op == OP_ST) && !misal;

  assign wr_d = wb_load ? (wb_misal ? '0 : mem_rd[XLEN-1:0]) : wb_alu_d;
  assign wr_t = wb_load ? (wb_misal ? POISON_ONLY : tag_t'(mem_rd[EW-1:XLEN])) : wb_alu_t;

  tag_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .we  (wb_valid),
    .wa  (wb_rd),
    .wd  (wr_d),
    .wt  (wr_t),
    .ra1 (iss_rs1),
    .ra2 (iss_rs2),
    .ra3 (obs_addr),
    .rd1 (s1_d),
    .rt1 (s1_t),
    .rd2 (s2_d),
    .rt2 (s2_t),
    .rd3 (ob_d),
    .rt3 (ob_t)
  );

  tag_mem #(.WIDTH(EW), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (addr[OFFB +: MAW]),
    .wdata ({s2_t, s2_d}),
    .rdata (mem_rd)
  );

  tag_alu #(.XLEN(XLEN)) u_alu (
    .op    (op),
    .a     (s1_d),
    .b     (s2_d),
    .ta    (s1_t),
    .tb    (s2_t),
    .imm   (iss_imm),
    .umask (iss_mask),
    .uset  (iss_mode),
    .res   (alu_d),
    .rtag  (alu_t)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_load  <= 1'b0;
      wb_misal <= 1'b0;
      wb_rd    <= '0;
      wb_alu_d <= '0;
      wb_alu_t <= '0;
      br_taken <= 1'b0;
      trap_req <= 1'b0;
      obs_data <= '0;
      obs_tag  <= '0;
    end else begin
      wb_valid <= fire && writes;
      wb_load  <= (op == OP_LD);
      wb_misal <= misal;
      wb_rd    <= iss_rd;
      wb_alu_d <= alu_d;
      wb_alu_t <= alu_t;
      br_taken <= fire && (op == OP_TEST) && !iss_mode && |(s1_t & iss_mask);
      trap_req <= fire && (op == OP_TEST) &&  iss_mode && |(s1_t & iss_mask);
      obs_data <= ob_d;
      obs_tag  <= ob_t;
    end
  end

  // R7
  test_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(br_taken && trap_req));

  // R7
  trap_src_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(fire && op == OP_TEST && iss_mode));

  // R6
  misal_poison_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_LD && misal) |=> (wb_valid && wr_d == '0 && wr_t == POISON_ONLY));

  // R3
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && is_arith) |=> ((($past(s1_t | s2_t) & STICKY_BITS) & ~wr_t) == '0));

  // R9
  no_overtake_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && iss_valid && writes && iss_rd == wb_rd) |-> !fire);
endmodule

// File: tb/tagged_exec_unit_test.sv
module tagged_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [3:0]  iss_op = '0;
  logic [3:0]  iss_rd = '0, iss_rs1 = '0, iss_rs2 = '0;
  logic [63:0] iss_imm = '0;
  logic [6:0]  iss_mask = '0;
  logic        iss_mode = 1'b0;
  logic        br_taken, trap_req;
  logic [3:0]  obs_addr = '0;
  logic [63:0] obs_data;
  logic [6:0]  obs_tag;

  int checks = 0;
  int errors = 0;
  int last_stalls = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tagged_exec_unit uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
    .iss_imm(iss_imm), .iss_mask(iss_mask), .iss_mode(iss_mode),
    .br_taken(br_taken), .trap_req(trap_req),
    .obs_addr(obs_addr), .obs_data(obs_data), .obs_tag(obs_tag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input int rd, input int rs1, input int rs2,
                       input logic [63:0] imm, input logic [6:0] mask, input bit mode);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 4'(op); iss_rd = 4'(rd); iss_rs1 = 4'(rs1);
    iss_rs2 = 4'(rs2); iss_imm = imm; iss_mask = mask; iss_mode = mode;
    last_stalls = 0;
    #1;
    while (!iss_ready) begin
      last_stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    iss_valid = 1'b0;
    #1;
  endtask

  task automatic read_reg(input int r, output logic [63:0] d, output logic [6:0] t);
    idle();
    @(negedge clk);
    obs_addr = 4'(r);
    @(negedge clk);
    #1;
    d = obs_data;
    t = obs_tag;
  endtask

  task automatic expect_reg(input string req, input int r, input logic [63:0] d, input logic [6:0] t);
    logic [63:0] ad;
    logic [6:0]  at;
    read_reg(r, ad, at);
    check({req, " data"}, ad, d);
    check({req, " tag"}, 64'(at), 64'(t));
  endtask

  task automatic t_reset();
    check("R10 ready", 64'(iss_ready), 64'd1);
    check("R10 br", 64'(br_taken), 64'd0);
    check("R10 trap", 64'(trap_req), 64'd0);
  endtask

  task automatic t_arith();
    issue(4, 1, 0, 0, 64'd5, '0, 0);
    issue(4, 2, 0, 0, -64'sd3, '0, 0);
    expect_reg("R4 ldi negative", 2, -64'sd3, 7'b001_0000);
    issue(0, 3, 1, 2, '0, '0, 0);
    expect_reg("R1 add carry", 3, 64'd2, 7'b000_0010);
    issue(1, 4, 1, 1, '0, '0, 0);
    expect_reg("R2 sub zero", 4, 64'd0, 7'b000_1000);
    issue(1, 5, 2, 1, '0, '0, 0);
    expect_reg("R2 sub negative", 5, -64'sd8, 7'b001_0000);
    issue(1, 5, 1, 2, '0, '0, 0);
    expect_reg("R1 sub borrow", 5, 64'd8, 7'b000_0010);
    issue(4, 6, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, '0, 0);
    issue(4, 7, 0, 0, 64'd1, '0, 0);
    issue(0, 8, 6, 7, '0, '0, 0);
    expect_reg("R1 add overflow", 8, 64'h8000_0000_0000_0000, 7'b001_0100);
    issue(2, 9, 1, 2, '0, '0, 0);
    expect_reg("R1 and", 9, 64'd5, 7'b000_0000);
    issue(3, 9, 1, 7, '0, '0, 0);
    expect_reg("R1 or", 9, 64'd5, 7'b000_0000);
  endtask

  task automatic t_poison();
    issue(4, 11, 0, 0, 64'h100, '0, 0);
    issue(5, 10, 11, 0, 64'd1, '0, 0);
    expect_reg("R6 misaligned load", 10, 64'd0, 7'b000_0001);
    issue(0, 12, 10, 1, '0, '0, 0);
    idle();
    check("R3 no trap on use", 64'(trap_req), 64'd0);
    expect_reg("R3 poison carried", 12, 64'd5, 7'b000_0001);
  endtask

  task automatic t_tagu();
    issue(8, 13, 12, 0, '0, 7'b110_0000, 1);
    expect_reg("R8 set user", 13, 64'd5, 7'b110_0001);
    issue(8, 14, 13, 0, '0, 7'b010_0001, 0);
    expect_reg("R8 clear user", 14, 64'd5, 7'b100_0001);
    issue(0, 15, 14, 7, '0, '0, 0);
    expect_reg("R3 user sticky", 15, 64'd6, 7'b100_0001);
  endtask

  task automatic t_mem();
    issue(6, 0, 11, 14, 64'd0, '0, 0);
    idle();
    check("R5 store no trap", 64'(trap_req), 64'd0);
    issue(5, 9, 11, 0, 64'd0, '0, 0);
    expect_reg("R5 load restores", 9, 64'd5, 7'b100_0001);
    issue(6, 0, 11, 1, 64'd4, '0, 0);
    issue(5, 9, 11, 0, 64'd0, '0, 0);
    expect_reg("R6 misaligned store ignored", 9, 64'd5, 7'b100_0001);
  endtask

  task automatic t_test();
    issue(7, 0, 14, 0, '0, 7'b000_0001, 0);
    idle();
    check("R7 branch taken", 64'(br_taken), 64'd1);
    check("R7 branch no trap", 64'(trap_req), 64'd0);
    idle();
    check("R7 branch pulse ends", 64'(br_taken), 64'd0);
    issue(7, 0, 14, 0, '0, 7'b000_0010, 1);
    idle();
    check("R7 no hit trap", 64'(trap_req), 64'd0);
    check("R7 no hit br", 64'(br_taken), 64'd0);
    issue(7, 0, 3, 0, '0, 7'b000_0010, 1);
    idle();
    check("R7 trap raised", 64'(trap_req), 64'd1);
    check("R7 trap no br", 64'(br_taken), 64'd0);
  endtask

  task automatic t_hazard();
    idle(); idle();
    issue(5, 9, 11, 0, 64'd0, '0, 0);
    issue(0, 10, 9, 7, '0, '0, 0);
    check("R9 raw stall", 64'(last_stalls), 64'd1);
    expect_reg("R9 raw value", 10, 64'd6, 7'b100_0001);
    issue(4, 5, 0, 0, 64'd1, '0, 0);
    issue(4, 5, 0, 0, 64'd2, '0, 0);
    check("R9 waw stall", 64'(last_stalls), 64'd1);
    expect_reg("R9 waw order", 5, 64'd2, 7'b000_0000);
    issue(4, 5, 0, 0, 64'd3, '0, 0);
    issue(4, 6, 0, 0, 64'd4, '0, 0);
    check("R9 independent no stall", 64'(last_stalls), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_arith();
    t_poison();
    t_tagu();
    t_mem();
    t_test();
    t_hazard();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule